// File: doc/BRIEF.md
# Double-Pumped Pre-Add Multiply-Accumulate Stage

This block is one arithmetic stage for a convolution datapath. It has two clocks. Operand capture and the result outputs run on a base clock. The arithmetic core runs on a fast clock that is phase-aligned with the base clock and runs at exactly twice its rate, so the one multiplier does two products in every base cycle.

In each base cycle the stage accepts two signed activation operands and two signed weights. The two activations are summed once in a pre-adder. That sum is multiplied by the first weight in the fast phase that starts at the base clock's rising edge, and by the second weight in the other phase. Each product is added to a cascade value that an upstream stage supplies at the fast rate. The sum is also driven out at the fast rate, so the next stage can chain on it.

The two fast-rate sums of one item are collected and presented together on two base-clock result ports. A valid flag goes with them. Throughput is one item per base cycle.

Top module: `dpmac_top`

## Requirements
- R1: While `rst_base_n` is sampled low, `out_valid` goes low and `res_0` and `res_1` go to zero. While `rst_fast_n` is sampled low, `casc_out` goes to zero.
- R2: For an item accepted with `in_valid` high, `res_0` equals (act_a + act_d) × wgt_0 + the first-phase cascade value, computed in two's complement and wrapped to RES_W bits.
- R3: For the same item, `res_1` equals (act_a + act_d) × wgt_1 + the second-phase cascade value, wrapped to RES_W bits.
- R4: The pre-add is signed and one bit wider than the activations, so it cannot overflow. With A = D = -128 and a weight of -128 the product is +32768, and with a weight of 127 it is -32512.
- R5: Inputs are sampled at base edge n. The result pair appears on the ports after base edge n+3, and `out_valid` is high for exactly that one base cycle. Each accepted item gives exactly one result pair.
- R6: A base cycle with `in_valid` low gives no `out_valid` pulse, whatever operands are applied. `res_0` and `res_1` keep their previous values while `out_valid` is low.
- R7: The first-phase cascade value is taken from `casc_in` during the fast cycle that begins at base edge n+1. The second-phase value is taken during the fast cycle after it. `casc_out` shows the first-phase sum during the fast cycle that begins in the middle of base cycle n+1, and the second-phase sum during the fast cycle that begins at base edge n+2.
- R8: Items may arrive on consecutive base cycles with no gap, and each still gets its own correct result pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Base clock for operand capture and result outputs |
| clk_fast | input | 1 | Arithmetic clock, twice the base rate, rising edges aligned with the base clock |
| rst_base_n | input | 1 | Synchronous active-low reset, base domain |
| rst_fast_n | input | 1 | Synchronous active-low reset, fast domain |
| in_valid | input | 1 | Operands on this base cycle form an item |
| act_a | input | ACT_W | Signed activation operand, first pre-adder input |
| act_d | input | ACT_W | Signed activation operand, second pre-adder input |
| wgt_0 | input | WGT_W | Signed weight used in the first fast phase |
| wgt_1 | input | WGT_W | Signed weight used in the second fast phase |
| casc_in | input | RES_W | Signed cascade value from upstream, fast rate |
| casc_out | output | RES_W | Signed post-add sum to downstream, fast rate |
| out_valid | output | 1 | Result pair is valid this base cycle |
| res_0 | output | RES_W | Signed result of the first-weight product |
| res_1 | output | RES_W | Signed result of the second-weight product |

## Verification
The assertions check, on every cycle, four things:
- reset clears the outputs;
- the outputs hold while no result is flagged;
- `out_valid` follows `in_valid` by exactly four base samples;
- the held activations stay stable across both fast phases, and every first-phase sum at the post-adder is followed at once by its second-phase partner.

Only the bench's scenarios can show the numbers themselves. These include correct weight-to-phase mapping, correct first/second cascade pairing, and correct `casc_out` timing. They also include signed extremes, such as the pre-add limits and a wrapping cascade.

// File: rtl/dpmac_pkg.sv
// Shared types and default sizes for the double-pumped pre-add MAC stage.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package dpmac_pkg;

    // Which fast phase of a base cycle a pipeline item belongs to
    typedef enum logic {
        LANE_LO = 1'b0,   // first phase, uses weight 0
        LANE_HI = 1'b1    // second phase, uses weight 1
    } lane_e;

    localparam int DEF_ACT_W = 8;
    localparam int DEF_WGT_W = 8;
    localparam int DEF_RES_W = 32;

endpackage

// File: rtl/dpmac_base_in.sv
// Base-domain operand capture: registers the activations, weights and
// valid flag once per base cycle, and flips a toggle on every base edge
// so that the fast domain can tell which of its phases follows a base edge.
// Assumes: inputs are synchronous to clk_base.
module dpmac_base_in #(
    parameter int ACT_W = dpmac_pkg::DEF_ACT_W,
    parameter int WGT_W = dpmac_pkg::DEF_WGT_W
) (
    input  logic                    clk_base,
    input  logic                    rst_base_n,
    input  logic                    in_valid,
    input  logic signed [ACT_W-1:0] act_a,
    input  logic signed [ACT_W-1:0] act_d,
    input  logic signed [WGT_W-1:0] wgt_0,
    input  logic signed [WGT_W-1:0] wgt_1,
    output logic signed [ACT_W-1:0] a_q,
    output logic signed [ACT_W-1:0] d_q,
    output logic signed [WGT_W-1:0] b0_q,
    output logic signed [WGT_W-1:0] b1_q,
    output logic                    v_q,
    output logic                    tgl_q
);

    // Hold operands for a full base cycle (both fast phases)
    always_ff @(posedge clk_base) begin
        if (!rst_base_n) begin
            a_q  <= '0;
            d_q  <= '0;
            b0_q <= '0;
            b1_q <= '0;
            v_q  <= 1'b0;
        end else begin
            a_q  <= act_a;
            d_q  <= act_d;
            b0_q <= wgt_0;
            b1_q <= wgt_1;
            v_q  <= in_valid;
        end
    end

    // Base-edge marker for the fast-domain phase detector
    always_ff @(posedge clk_base) begin
        if (!rst_base_n) tgl_q <= 1'b0;
        else             tgl_q <= ~tgl_q;
    end

endmodule

// File: rtl/dpmac_preadd_sel.sv
// Fast-domain stage 1: detects the phase, forms the widened signed pre-add
// sum and picks the weight for this phase.
// Assumes: clk_fast is twice clk_base, with rising edges aligned. A fast edge
// that sees the base toggle differ from its last sample is the one in the
// middle of a base cycle, which is the first phase for the operands held then.
module dpmac_preadd_sel
    import dpmac_pkg::*;
#(
    parameter int ACT_W = DEF_ACT_W,
    parameter int WGT_W = DEF_WGT_W,
    localparam int PRE_W = ACT_W + 1
) (
    input  logic                    clk_fast,
    input  logic                    rst_fast_n,
    input  logic signed [ACT_W-1:0] a_q,
    input  logic signed [ACT_W-1:0] d_q,
    input  logic signed [WGT_W-1:0] b0_q,
    input  logic signed [WGT_W-1:0] b1_q,
    input  logic                    v_q,
    input  logic                    tgl_q,
    output logic signed [PRE_W-1:0] pre_q,
    output logic signed [WGT_W-1:0] wsel_q,
    output logic                    v1,
    output lane_e                   lane1
);

    logic                    seen_q;
    logic                    first_ph;
    logic signed [PRE_W-1:0] pre_d;

    // Remember the base toggle as the fast domain last saw it
    always_ff @(posedge clk_fast) begin
        if (!rst_fast_n) seen_q <= 1'b0;
        else             seen_q <= tgl_q;
    end

    // Phase decode and widened signed pre-add
    always_comb begin
        first_ph = tgl_q ^ seen_q;
        pre_d    = PRE_W'(a_q) + PRE_W'(d_q);
    end

    // Stage-1 register: pre-add sum, phase weight, valid, lane
    always_ff @(posedge clk_fast) begin
        if (!rst_fast_n) begin
            pre_q  <= '0;
            wsel_q <= '0;
            v1     <= 1'b0;
            lane1  <= LANE_LO;
        end else begin
            pre_q  <= pre_d;
            wsel_q <= first_ph ? b0_q : b1_q;
            v1     <= v_q;
            lane1  <= first_ph ? LANE_LO : LANE_HI;
        end
    end

endmodule

// File: rtl/dpmac_mul_post.sv
// Fast-domain stages 2 and 3: signed multiply, then post-add with the
// cascade input. The post-add register is the cascade output.
// Assumes: RES_W is at least as wide as the full product; the sum wraps.
module dpmac_mul_post
    import dpmac_pkg::*;
#(
    parameter int PRE_W = DEF_ACT_W + 1,
    parameter int WGT_W = DEF_WGT_W,
    parameter int RES_W = DEF_RES_W,
    localparam int PROD_W = PRE_W + WGT_W
) (
    input  logic                    clk_fast,
    input  logic                    rst_fast_n,
    input  logic signed [PRE_W-1:0] pre_q,
    input  logic signed [WGT_W-1:0] wsel_q,
    input  logic                    v1,
    input  lane_e                   lane1,
    input  logic signed [RES_W-1:0] casc_in,
    output logic signed [RES_W-1:0] acc_q,
    output logic                    v3,
    output lane_e                   lane3
);

    logic signed [PROD_W-1:0] prod_q;
    logic signed [RES_W-1:0]  prod_ext;
    logic                     v2;
    lane_e                    lane2;

    // Stage-2 register: full-precision signed product
    always_ff @(posedge clk_fast) begin
        if (!rst_fast_n) begin
            prod_q <= '0;
            v2     <= 1'b0;
            lane2  <= LANE_LO;
        end else begin
            prod_q <= PROD_W'(pre_q) * PROD_W'(wsel_q);
            v2     <= v1;
            lane2  <= lane1;
        end
    end

    // Product widening to the cascade width; parameter picks the variant
    generate
        if (RES_W > PROD_W) begin : g_ext
            assign prod_ext = {{(RES_W-PROD_W){prod_q[PROD_W-1]}}, prod_q};
        end else begin : g_same
            assign prod_ext = prod_q[RES_W-1:0];
        end
    endgenerate

    // Stage-3 register: post-add with the upstream cascade
    always_ff @(posedge clk_fast) begin
        if (!rst_fast_n) begin
            acc_q <= '0;
            v3    <= 1'b0;
            lane3 <= LANE_LO;
        end else begin
            acc_q <= prod_ext + casc_in;
            v3    <= v2;
            lane3 <= lane2;
        end
    end

endmodule

// File: rtl/dpmac_demux.sv
// Splits the fast-rate sum stream into two base-clock results. The
// first-phase sum is delayed one fast cycle so that it pairs with its
// second-phase partner. The pair is then re-registered on the base clock.
// Assumes: the first-phase item always reaches the post-adder one fast
// cycle before its partner, and the pair register is loaded at a mid-cycle
// fast edge, so it is stable at the next base edge.
module dpmac_demux
    import dpmac_pkg::*;
#(
    parameter int RES_W = DEF_RES_W
) (
    input  logic                    clk_fast,
    input  logic                    rst_fast_n,
    input  logic                    clk_base,
    input  logic                    rst_base_n,
    input  logic signed [RES_W-1:0] acc_q,
    input  logic                    v3,
    input  lane_e                   lane3,
    output logic                    out_valid,
    output logic signed [RES_W-1:0] res_0,
    output logic signed [RES_W-1:0] res_1
);

    logic signed [RES_W-1:0] hold0_q;
    logic signed [RES_W-1:0] pair0_q;
    logic signed [RES_W-1:0] pair1_q;
    logic                    pv_q;

    // Delay the first-phase sum one fast cycle
    always_ff @(posedge clk_fast) begin
        if (!rst_fast_n)                  hold0_q <= '0;
        else if (v3 && lane3 == LANE_LO) hold0_q <= acc_q;
    end

    // Form the aligned pair when the second-phase sum arrives
    always_ff @(posedge clk_fast) begin
        if (!rst_fast_n) begin
            pair0_q <= '0;
            pair1_q <= '0;
            pv_q    <= 1'b0;
        end else begin
            pv_q <= v3 && lane3 == LANE_HI;
            if (v3 && lane3 == LANE_HI) begin
                pair0_q <= hold0_q;
                pair1_q <= acc_q;
            end
        end
    end

    // Base-clock result registers, holding between valid pairs
    always_ff @(posedge clk_base) begin
        if (!rst_base_n) begin
            out_valid <= 1'b0;
            res_0     <= '0;
            res_1     <= '0;
        end else begin
            out_valid <= pv_q;
            if (pv_q) begin
                res_0 <= pair0_q;
                res_1 <= pair1_q;
            end
        end
    end

endmodule

// File: rtl/dpmac_top.sv
// Double-pumped pre-add multiply-accumulate stage. Operands are captured on
// the base clock. One multiplier is used twice per base cycle on the fast
// clock, once per weight. The sums leave on a fast-rate cascade and are
// paired back onto two base-clock result ports.
// Assumes: clk_fast = 2 x clk_base, phase-aligned, from a common source.
module dpmac_top
    import dpmac_pkg::*;
#(
    parameter int ACT_W = DEF_ACT_W,
    parameter int WGT_W = DEF_WGT_W,
    parameter int RES_W = DEF_RES_W,
    localparam int PRE_W = ACT_W + 1
) (
    input  logic                    clk_base,
    input  logic                    clk_fast,
    input  logic                    rst_base_n,
    input  logic                    rst_fast_n,
    input  logic                    in_valid,
    input  logic signed [ACT_W-1:0] act_a,
    input  logic signed [ACT_W-1:0] act_d,
    input  logic signed [WGT_W-1:0] wgt_0,
    input  logic signed [WGT_W-1:0] wgt_1,
    input  logic signed [RES_W-1:0] casc_in,
    output logic signed [RES_W-1:0] casc_out,
    output logic                    out_valid,
    output logic signed [RES_W-1:0] res_0,
    output logic signed [RES_W-1:0] res_1
);

    logic signed [ACT_W-1:0] a_q;
    logic signed [ACT_W-1:0] d_q;
    logic signed [WGT_W-1:0] b0_q;
    logic signed [WGT_W-1:0] b1_q;
    logic                    v_q;
    logic                    tgl_q;
    logic signed [PRE_W-1:0] pre_q;
    logic signed [WGT_W-1:0] wsel_q;
    logic                    v1;
    lane_e                   lane1;
    logic signed [RES_W-1:0] acc_q;
    logic                    v3;
    lane_e                   lane3;

    dpmac_base_in #(.ACT_W(ACT_W), .WGT_W(WGT_W)) u_base_in (
        .clk_base(clk_base), .rst_base_n(rst_base_n), .in_valid(in_valid),
        .act_a(act_a), .act_d(act_d), .wgt_0(wgt_0), .wgt_1(wgt_1),
        .a_q(a_q), .d_q(d_q), .b0_q(b0_q), .b1_q(b1_q),
        .v_q(v_q), .tgl_q(tgl_q)
    );

    dpmac_preadd_sel #(.ACT_W(ACT_W), .WGT_W(WGT_W)) u_preadd (
        .clk_fast(clk_fast), .rst_fast_n(rst_fast_n),
        .a_q(a_q), .d_q(d_q), .b0_q(b0_q), .b1_q(b1_q),
        .v_q(v_q), .tgl_q(tgl_q),
        .pre_q(pre_q), .wsel_q(wsel_q), .v1(v1), .lane1(lane1)
    );

    dpmac_mul_post #(.PRE_W(PRE_W), .WGT_W(WGT_W), .RES_W(RES_W)) u_mul_post (
        .clk_fast(clk_fast), .rst_fast_n(rst_fast_n),
        .pre_q(pre_q), .wsel_q(wsel_q), .v1(v1), .lane1(lane1),
        .casc_in(casc_in), .acc_q(acc_q), .v3(v3), .lane3(lane3)
    );

    dpmac_demux #(.RES_W(RES_W)) u_demux (
        .clk_fast(clk_fast), .rst_fast_n(rst_fast_n),
        .clk_base(clk_base), .rst_base_n(rst_base_n),
        .acc_q(acc_q), .v3(v3), .lane3(lane3),
        .out_valid(out_valid), .res_0(res_0), .res_1(res_1)
    );

    // Cascade output is the post-add register itself
    assign casc_out = acc_q;

endmodule

// File: rtl/dpmac_chk.sv
// Property checker for dpmac_top, attached with bind. Watches ports and the
// nets between the capture, pre-add, post-add and demux pieces.
// Assumes: both resets are held for at least two base cycles at start-up.
module dpmac_chk
    import dpmac_pkg::*;
#(
    parameter int ACT_W = DEF_ACT_W,
    parameter int RES_W = DEF_RES_W
) (
    input logic                    clk_base,
    input logic                    clk_fast,
    input logic                    rst_base_n,
    input logic                    rst_fast_n,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [RES_W-1:0] res_0,
    input logic signed [RES_W-1:0] res_1,
    input logic signed [ACT_W-1:0] a_q,
    input logic signed [ACT_W-1:0] d_q,
    input logic                    v1,
    input lane_e                   lane1,
    input logic                    v3,
    input lane_e                   lane3
);

    logic [2:0] age_q;

    // Count base cycles since both resets were released (saturating)
    always_ff @(posedge clk_base) begin
        if (!rst_base_n || !rst_fast_n) age_q <= '0;
        else if (age_q != 3'd7)         age_q <= age_q + 3'd1;
    end

    // R1: base reset clears valid and both results
    p_reset_clear_r1: assert property (@(posedge clk_base)
        !rst_base_n |=> (!out_valid && res_0 == '0 && res_1 == '0));

    // R5: out_valid follows in_valid by four base samples
    p_latency_r5: assert property (@(posedge clk_base)
        disable iff (!rst_base_n || !rst_fast_n)
        (age_q >= 3'd6) |-> (out_valid == $past(in_valid, 4)));

    // R6: results hold while nothing is flagged
    p_hold_idle_r6: assert property (@(posedge clk_base)
        disable iff (!rst_base_n || !rst_fast_n)
        (age_q >= 3'd2 && !out_valid) |-> ($stable(res_0) && $stable(res_1)));

    // R2: both phases of one item see the same held activations
    p_operand_hold_r2: assert property (@(posedge clk_fast)
        disable iff (!rst_fast_n || !rst_base_n)
        (v1 && lane1 == LANE_LO) |-> ($stable(a_q) && $stable(d_q)));

    // R8: a first-phase sum is always followed at once by its partner
    p_lane_pair_r8: assert property (@(posedge clk_fast)
        disable iff (!rst_fast_n)
        (v3 && lane3 == LANE_LO) |=> (v3 && lane3 == LANE_HI));

endmodule

bind dpmac_top dpmac_chk #(.ACT_W(ACT_W), .RES_W(RES_W)) u_chk (
    .clk_base(clk_base), .clk_fast(clk_fast),
    .rst_base_n(rst_base_n), .rst_fast_n(rst_fast_n),
    .in_valid(in_valid), .out_valid(out_valid),
    .res_0(res_0), .res_1(res_1),
    .a_q(a_q), .d_q(d_q), .v1(v1), .lane1(lane1),
    .v3(v3), .lane3(lane3)
);

// File: tb/dpmac_top_test.sv
// Scoreboard bench: the driver task pushes expected result pairs, and the
// monitor pops them when out_valid is seen on the base clock.
module dpmac_top_test;

    logic clk_f = 1'b0;
    logic clk_b = 1'b0;
    logic rst_b_n = 1'b0;
    logic rst_f_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [7:0]  act_a = '0, act_d = '0, wgt_0 = '0, wgt_1 = '0;
    logic signed [31:0] casc_in = '0;
    logic signed [31:0] casc_out, res_0, res_1;
    logic out_valid;

    // 250 MHz fast clock; base clock at half rate, rising with it
    initial forever #2 clk_f = ~clk_f;
    initial begin
        #2;
        forever begin clk_b = 1'b1; #4; clk_b = 1'b0; #4; end
    end

    dpmac_top uut (
        .clk_base(clk_b), .clk_fast(clk_f), .rst_base_n(rst_b_n), .rst_fast_n(rst_f_n),
        .in_valid(in_valid), .act_a(act_a), .act_d(act_d), .wgt_0(wgt_0), .wgt_1(wgt_1),
        .casc_in(casc_in), .casc_out(casc_out), .out_valid(out_valid),
        .res_0(res_0), .res_1(res_1)
    );

    typedef struct { int r0; int r1; int stamp; string tag; } exp_t;
    exp_t sb[$];
    int checks = 0, errors = 0;
    int unsigned bcount = 0;
    bit mon_on = 1'b0, done = 1'b0;
    bit h_v[4];
    int h_c0[4], h_c1[4], h_r0[4], h_r1[4];
    int last0 = 0, last1 = 0;

    always @(posedge clk_b) bcount <= bcount + 1;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    // One base cycle: drive an item (or idle), drive and check the cascade
    task automatic step(input bit v, input int a, input int d, input int b0,
                        input int b1, input int c0, input int c1, input string tag);
        int unsigned n;
        exp_t e;
        @(negedge clk_f);
        while (!clk_b) @(negedge clk_f);
        n = bcount;
        if (h_v[(n+1)%4]) check("R7 casc_out second phase", casc_out, h_r1[(n+1)%4]);
        casc_in  = h_v[(n+2)%4] ? h_c0[(n+2)%4] : int'($urandom);
        in_valid = v;
        act_a = a[7:0]; act_d = d[7:0]; wgt_0 = b0[7:0]; wgt_1 = b1[7:0];
        h_v[n%4]  = v;
        h_c0[n%4] = c0;
        h_c1[n%4] = c1;
        h_r0[n%4] = (a + d) * b0 + c0;
        h_r1[n%4] = (a + d) * b1 + c1;
        if (v) begin
            e.r0 = h_r0[n%4]; e.r1 = h_r1[n%4]; e.stamp = int'(n); e.tag = tag;
            sb.push_back(e);
        end
        @(negedge clk_f);
        if (h_v[(n+2)%4]) check("R7 casc_out first phase", casc_out, h_r0[(n+2)%4]);
        casc_in = h_v[(n+2)%4] ? h_c1[(n+2)%4] : int'($urandom);
    endtask

    function automatic int rs8();
        return int'($urandom_range(255)) - 128;
    endfunction

    // Monitor: compare result pairs and latency in the first half of each base cycle
    always @(negedge clk_f) begin
        if (mon_on && clk_b) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R6 unexpected out_valid got 1 expected 0");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " R2 res_0"}, res_0, e.r0);
                    check({e.tag, " R3 res_1"}, res_1, e.r1);
                    check("R5 latency", int'(bcount), e.stamp + 4);
                end
                last0 = res_0;
                last1 = res_1;
            end else begin
                check("R6 res_0 held", res_0, last0);
                check("R6 res_1 held", res_1, last1);
                if (sb.size() != 0 && sb[0].stamp + 4 <= int'(bcount)) begin
                    checks++; errors++;
                    $display("FAIL R5 missing result got none expected stamp %0d", sb[0].stamp);
                    void'(sb.pop_front());
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) h_v[i] = 1'b0;
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0, 0, "");
        rst_b_n = 1'b1;
        rst_f_n = 1'b1;
        // R1: reset state before the first edge out of reset
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 res_0", res_0, 0);
        check("R1 res_1", res_1, 0);
        check("R1 casc_out", casc_out, 0);
        mon_on = 1'b1;

        // R8: back-to-back random items
        for (int i = 0; i < 30; i++)
            step(1, rs8(), rs8(), rs8(), rs8(), int'($urandom), int'($urandom), "R8");

        // R4: pre-add extremes and a wrapping cascade
        step(1, -128, -128, -128, 127, 0, 0, "R4");
        step(1, 127, 127, 127, -128, 0, 0, "R4");
        step(1, -128, -128, -128, -128, 32'h7fffffff, -1, "R4");
        step(1, 127, -128, 0, 1, 5, -5, "R4");

        // R6: idle cycles with garbage operands between items
        for (int i = 0; i < 10; i++) begin
            step(1, rs8(), rs8(), rs8(), rs8(), int'($urandom), int'($urandom), "R6");
            step(0, rs8(), rs8(), rs8(), rs8(), int'($urandom), int'($urandom), "");
            step(0, rs8(), rs8(), rs8(), rs8(), int'($urandom), int'($urandom), "");
        end

        // R2/R3: zero cascade, so weight-to-phase mapping is exposed alone
        for (int i = 0; i < 8; i++) step(1, rs8(), rs8(), rs8(), rs8(), 0, 0, "R2R3");

        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 0, "");
        check("R5 all results delivered", sb.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        done = 1'b1;
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule